// File: doc/BRIEF.md
# Double-Clock Acquisition Window Sequencer

This block sits in front of a multiplexed sampling converter. It takes two pulse streams and turns them into one stream of conversion strobes. The first stream is a scan clock, which opens an acquisition window. The second is a conversion clock, which is converted only while a window is open. Each strobe carries the index of the channel to convert. Inside a window the channel walks upward from a programmed first channel to a programmed last channel. That walk repeats for a programmed number of passes. The window then shuts by itself and waits for the next scan clock.

Scan clocks that arrive too early and conversion clocks that arrive outside a window are dropped. This keeps mismatched clock rates from producing stray conversions. A single-clock option feeds the conversion clock into the window logic in place of the scan clock, so one external source drives the whole sequence. A running count of accepted scan clocks is kept for readback.

Top module: `acq_window_seq`

## Requirements
- R1: After reset, `window_o` is 0, `conv_strobe_o` is 0, `chan_o` is 0 and `scan_count_o` is 0.
- R2: A scan pulse sampled while the window is closed and the configuration is valid sets `window_o` to 1 in the next cycle. In that same cycle `scan_count_o` rises by exactly one.
- R3: A conversion pulse sampled while the window is open gives a one-cycle `conv_strobe_o` in the next cycle, with `chan_o` holding the channel converted. Successive strobes step the channel by one, from the first channel up to the last channel. The channel then returns to the first channel for the next pass.
- R4: After the programmed number of full passes, `window_o` reads 0 in the same cycle as the final strobe of the window.
- R5: A conversion pulse sampled while the window is closed produces no strobe.
- R6: A scan pulse sampled while the window is open is ignored. `scan_count_o` does not change, and the channel sequence and window length are unaffected.
- R7: With `single_clk_i` = 1, a conversion pulse sampled while the window is closed opens the window and counts as a scan. That pulse is not itself converted. `scan_pulse_i` has no effect in this mode.
- R8: A configuration with last channel below first channel, or with a pass count of 0, is invalid. A scan pulse under an invalid configuration opens no window and leaves `scan_count_o` unchanged.
- R9: First channel, last channel and pass count are captured when the window opens. Changes to these inputs during an open window have no effect until the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_pulse_i | input | 1 | Scan clock pulse, one cycle per event |
| conv_pulse_i | input | 1 | Conversion clock pulse, one cycle per event |
| single_clk_i | input | 1 | 1: conversion clock also serves as the scan clock |
| first_ch_i | input | CH_W (4) | First channel of each pass |
| last_ch_i | input | CH_W (4) | Last channel of each pass |
| passes_i | input | IT_W (8) | Number of passes per window |
| conv_strobe_o | output | 1 | One-cycle conversion strobe |
| chan_o | output | CH_W (4) | Channel of the current strobe |
| window_o | output | 1 | Acquisition window open |
| scan_count_o | output | SC_W (16) | Count of accepted scan clocks |

## Verification
On every cycle the assertions enforce the following. No strobe appears unless the window was open. The window only closes together with a strobe. Every strobed channel lies inside the captured range. The scan count moves only when a window opens. An invalid configuration or a scan pulse in single-clock mode never opens a window. The exact channel order across pass boundaries, the pass count at which the window closes, and the capture of the configuration at window opening can only be shown by the bench scenarios. There a scoreboard compares every strobe with the channel list predicted by each scenario.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} win_state_e;
endpackage

// File: rtl/acq_cfg_check.sv
module acq_cfg_check #(
  parameter int CH_W = 4,
  parameter int IT_W = 8
) (
  input  logic [CH_W-1:0] first_ch_i,
  input  logic [CH_W-1:0] last_ch_i,
  input  logic [IT_W-1:0] passes_i,
  output logic            cfg_ok_o
);
  always_comb begin
    cfg_ok_o = (last_ch_i >= first_ch_i) && (passes_i != '0);
  end
endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl
  import acq_seq_pkg::*;
#(
  parameter int SC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_i,
  input  logic            cfg_ok_i,
  input  logic            close_i,
  output logic            open_o,
  output logic            active_o,
  output logic [SC_W-1:0] scan_cnt_o
);
  win_state_e      state_q;
  logic [SC_W-1:0] scan_cnt_q;

  assign open_o     = (state_q == WIN_IDLE) && scan_i && cfg_ok_i;
  assign active_o   = (state_q == WIN_OPEN);
  assign scan_cnt_o = scan_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= WIN_IDLE;
      scan_cnt_q <= '0;
    end else begin
      unique case (state_q)
        WIN_IDLE: if (open_o) begin
          state_q    <= WIN_OPEN;
          scan_cnt_q <= scan_cnt_q + 1'b1;
        end
        WIN_OPEN: if (close_i) state_q <= WIN_IDLE;
        default:  state_q <= WIN_IDLE;
      endcase
    end
  end

  p_cfg_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_IDLE && !cfg_ok_i) |=> (state_q == WIN_IDLE && $stable(scan_cnt_q)));

  p_scan_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_OPEN && scan_i) |=> $stable(scan_cnt_q));

  p_count_on_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(active_o) |-> $stable(scan_cnt_q));
endmodule

// File: rtl/acq_chan_stepper.sv
module acq_chan_stepper #(
  parameter int CH_W = 4,
  parameter int IT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            open_i,
  input  logic            conv_i,
  input  logic [CH_W-1:0] first_ch_i,
  input  logic [CH_W-1:0] last_ch_i,
  input  logic [IT_W-1:0] passes_i,
  output logic            close_o,
  output logic            strobe_o,
  output logic [CH_W-1:0] chan_o
);
  logic [CH_W-1:0] first_q, last_q, cur_q, chan_q;
  logic [IT_W-1:0] left_q;
  logic            strobe_q;
  logic            at_last;

  assign at_last  = (cur_q == last_q);
  assign close_o  = conv_i && at_last && (left_q == IT_W'(1));
  assign strobe_o = strobe_q;
  assign chan_o   = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      last_q   <= '0;
      cur_q    <= '0;
      left_q   <= '0;
      chan_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= conv_i;
      if (open_i) begin
        first_q <= first_ch_i;
        last_q  <= last_ch_i;
        cur_q   <= first_ch_i;
        left_q  <= passes_i;
      end else if (conv_i) begin
        chan_q <= cur_q;
        if (at_last) begin
          cur_q  <= first_q;
          // reload the pass counter on close, else count one pass down
          left_q <= close_o ? passes_i : left_q - 1'b1;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  p_chan_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> (chan_q >= first_q && chan_q <= last_q));

  p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_i |=> !strobe_q);
endmodule

// File: rtl/acq_window_seq.sv
module acq_window_seq #(
  parameter int CH_W = 4,
  parameter int IT_W = 8,
  parameter int SC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_pulse_i,
  input  logic            conv_pulse_i,
  input  logic            single_clk_i,
  input  logic [CH_W-1:0] first_ch_i,
  input  logic [CH_W-1:0] last_ch_i,
  input  logic [IT_W-1:0] passes_i,
  output logic            conv_strobe_o,
  output logic [CH_W-1:0] chan_o,
  output logic            window_o,
  output logic [SC_W-1:0] scan_count_o
);
  logic cfg_ok, eff_scan, win_open, active, conv_q, close;

  assign eff_scan = single_clk_i ? conv_pulse_i : scan_pulse_i;
  assign conv_q   = active && conv_pulse_i;
  assign window_o = active;

  acq_cfg_check #(.CH_W(CH_W), .IT_W(IT_W)) u_cfg (
    .first_ch_i (first_ch_i),
    .last_ch_i  (last_ch_i),
    .passes_i   (passes_i),
    .cfg_ok_o   (cfg_ok)
  );

  acq_window_ctrl #(.SC_W(SC_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_i     (eff_scan),
    .cfg_ok_i   (cfg_ok),
    .close_i    (close),
    .open_o     (win_open),
    .active_o   (active),
    .scan_cnt_o (scan_count_o)
  );

  acq_chan_stepper #(.CH_W(CH_W), .IT_W(IT_W)) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (win_open),
    .conv_i     (conv_q),
    .first_ch_i (first_ch_i),
    .last_ch_i  (last_ch_i),
    .passes_i   (passes_i),
    .close_o    (close),
    .strobe_o   (conv_strobe_o),
    .chan_o     (chan_o)
  );

  p_strobe_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_o |-> $past(window_o));

  p_close_with_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(window_o) |-> conv_strobe_o);

  p_single_ignores_scan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_clk_i && !window_o && !conv_pulse_i) |=> !window_o);
endmodule

// File: tb/sim_acq_window_seq.sv
`timescale 1ns/1ps
module sim_acq_window_seq;
  localparam int CH_W = 4;
  localparam int IT_W = 8;
  localparam int SC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan = 1'b0, conv = 1'b0, single = 1'b0;
  logic [CH_W-1:0] first_ch = '0, last_ch = '0;
  logic [IT_W-1:0] passes = '0;
  logic            strobe, win;
  logic [CH_W-1:0] chan;
  logic [SC_W-1:0] scans;

  int total = 0, bad = 0;
  int exp_scans = 0;
  bit done = 1'b0;
  logic [CH_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  acq_window_seq #(.CH_W(CH_W), .IT_W(IT_W), .SC_W(SC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scan_pulse_i(scan), .conv_pulse_i(conv),
    .single_clk_i(single), .first_ch_i(first_ch), .last_ch_i(last_ch),
    .passes_i(passes), .conv_strobe_o(strobe), .chan_o(chan),
    .window_o(win), .scan_count_o(scans)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard (R3, R5)
  always @(negedge clk) begin
    if (rst_n && strobe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", int'(chan), -1);
      end else begin
        automatic logic [CH_W-1:0] e = exp_q.pop_front();
        check(chan == e, "R3 strobe channel", int'(chan), int'(e));
      end
    end
  end

  task automatic tick(input logic s, input logic c);
    @(negedge clk);
    scan = s;
    conv = c;
    @(negedge clk);
    scan = 1'b0;
    conv = 1'b0;
  endtask

  task automatic conv_exp(input logic [CH_W-1:0] ch);
    exp_q.push_back(ch);
    tick(1'b0, 1'b1);
  endtask

  task automatic open_win(input string req);
    tick(1'b1, 1'b0);
    exp_scans++;
    check(win == 1'b1, req, int'(win), 1);
    check(int'(scans) == exp_scans, req, int'(scans), exp_scans);
  endtask

  // run every pass of a window; last strobe must coincide with closing (R4)
  task automatic run_passes(input int f, input int l, input int n);
    for (int p = 0; p < n; p++) begin
      for (int c = f; c <= l; c++) begin
        conv_exp(CH_W'(c));
        if (p == n - 1 && c == l) begin
          check(win == 1'b0, "R4 window closes on final strobe", int'(win), 0);
          check(strobe == 1'b1, "R4 strobe with close", int'(strobe), 1);
        end else begin
          check(win == 1'b1, "R4 window held open", int'(win), 1);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(win == 1'b0, "R1 window", int'(win), 0);
    check(strobe == 1'b0, "R1 strobe", int'(strobe), 0);
    check(chan == '0, "R1 chan", int'(chan), 0);
    check(scans == '0, "R1 scan count", int'(scans), 0);
    rst_n = 1'b1;

    // R5 conversion clocks with no window
    tick(1'b0, 1'b1);
    check(strobe == 1'b0, "R5 no strobe outside window", int'(strobe), 0);

    // R2/R3/R4 normal window: channels 2..4, two passes
    first_ch = 4'd2; last_ch = 4'd4; passes = 8'd2;
    open_win("R2 window opens and counts");
    conv_exp(4'd2);
    // R6 early scan pulse inside the window is ignored
    tick(1'b1, 1'b0);
    check(int'(scans) == exp_scans, "R6 scan count unchanged", int'(scans), exp_scans);
    exp_q.push_back(4'd3);
    tick(1'b1, 1'b1);
    check(int'(scans) == exp_scans, "R6 scan with conv ignored", int'(scans), exp_scans);
    conv_exp(4'd4);
    conv_exp(4'd2);
    conv_exp(4'd3);
    conv_exp(4'd4);
    check(win == 1'b0, "R4 closed after two passes", int'(win), 0);
    tick(1'b0, 1'b1);
    check(strobe == 1'b0, "R5 surplus conv gated", int'(strobe), 0);

    // R3 single channel, three passes
    first_ch = 4'd7; last_ch = 4'd7; passes = 8'd3;
    open_win("R2 second window");
    run_passes(7, 7, 3);

    // R9 configuration captured at open
    first_ch = 4'd0; last_ch = 4'd1; passes = 8'd1;
    open_win("R2 window before cfg change");
    first_ch = 4'd5; last_ch = 4'd9; passes = 8'd4;
    run_passes(0, 1, 1);
    // R9 next window uses the new values
    open_win("R9 new cfg window");
    run_passes(5, 9, 4);

    // R8 invalid configurations
    first_ch = 4'd6; last_ch = 4'd3; passes = 8'd1;
    tick(1'b1, 1'b0);
    check(win == 1'b0, "R8 last below first", int'(win), 0);
    check(int'(scans) == exp_scans, "R8 count unchanged", int'(scans), exp_scans);
    first_ch = 4'd1; last_ch = 4'd3; passes = 8'd0;
    tick(1'b1, 1'b0);
    check(win == 1'b0, "R8 zero passes", int'(win), 0);
    check(int'(scans) == exp_scans, "R8 count unchanged zero", int'(scans), exp_scans);

    // R7 single-clock mode
    single = 1'b1; first_ch = 4'd1; last_ch = 4'd3; passes = 8'd1;
    tick(1'b1, 1'b0);
    check(win == 1'b0, "R7 scan pin ignored", int'(win), 0);
    check(int'(scans) == exp_scans, "R7 scan pin not counted", int'(scans), exp_scans);
    tick(1'b0, 1'b1);
    exp_scans++;
    check(win == 1'b1, "R7 conv opens window", int'(win), 1);
    check(strobe == 1'b0, "R7 opening pulse not converted", int'(strobe), 0);
    check(int'(scans) == exp_scans, "R7 counted as scan", int'(scans), exp_scans);
    run_passes(1, 3, 1);
    single = 1'b0;

    // R3 full channel range, one pass
    first_ch = 4'd0; last_ch = 4'd15; passes = 8'd1;
    open_win("R2 full range window");
    run_passes(0, 15, 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule